// File: doc/BRIEF.md
# Periodic Down-Counter Timer Bank

This block holds three identical 16-bit periodic timers behind one simple 32-bit register bus. Each timer has its own 256-byte window. Inside that window there are three registers: a control word, a reload value and a read-only live count. Once started, a timer counts down by one on every tick of a 1 MHz time base. The block derives that tick from the system clock with an internal prescaler. When the count has reached zero, the next tick puts the reload value back into it, and the timer keeps running without stopping.

Software starts a timer by writing the control word with the start bit set. A timer stops only through a soft reset: a control write with the top bit set clears that timer completely, and nothing from that write is kept. Writing the reload register also loads the live count with the same value at once. Reads are combinational, and every access is a full 32-bit word. Offsets that decode to no register read as zero, and writes to them are dropped.

Top module: `tmr_bank`

## Requirements
- R1: After hardware reset, every timer is stopped, and its control, reload and count registers all read zero.
- R2: A write to the control register (offset 0x00) with bit 31 set clears control, reload and count to zero and stops the timer. No part of the written word is kept.
- R3: A control write with bit 31 clear and bit 0 set starts the timer. The whole written word is stored and reads back at offset 0x00.
- R4: A control write with bit 0 clear (bit 31 clear) stores the word but does not stop a timer that is already running.
- R5: A write to the reload register (offset 0x08) keeps only bits [15:0]. From the next clock, both the reload register and the live count hold that value.
- R6: A read of offset 0x0C returns the live count in bits [15:0], with bits [31:16] zero. Writes to offset 0x0C change nothing.
- R7: A running timer changes its count exactly once in every CLK_HZ/1_000_000 clocks. If the count is nonzero it goes down by one. If it is zero it is loaded with the reload value, so one period lasts reload+1 ticks.
- R8: If the reload value is zero while the timer runs, the count stays at zero.
- R9: Timer n answers at BASE_ADDR + n*0x100 for n = 0, 1, 2. An access to one timer never changes another.
- R10: Reads of offsets other than 0x00, 0x08 and 0x0C, and reads of addresses outside the three windows, return zero. Writes to those addresses change nothing.
- R11: Every start write and every soft reset clears the tick prescaler. The first count change after a start therefore happens exactly CLK_HZ/1_000_000 clocks after the write, even if the timer was already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| bus_addr | input | ADDR_W | Full byte address of a 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench targets the priority rules at a write edge and the exact tick phase. These include a restart write landing mid-period, a control write that clears bit 0 on a running timer, a reload write on a running timer, and the wrap from zero back to the reload value. A design that let bit 0 stop the counter would freeze the count after the R4 write. A design that kept any part of a soft-reset word would read back 0x80000001. A design that failed to clear the prescaler on a restart would change the count early, and a design with an off-by-one divider would drift away from the reference model within one tick. Unmapped offsets, the hole past the third window, and cross-instance writes are probed so that decode aliasing shows up as nonzero reads or corrupted neighbours.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned COUNT_W  = 16;
    localparam int unsigned WIN_BITS = 8;

    // register offsets inside one timer window
    localparam logic [WIN_BITS-1:0] OFS_CTRL   = 8'h00;
    localparam logic [WIN_BITS-1:0] OFS_RELOAD = 8'h08;
    localparam logic [WIN_BITS-1:0] OFS_COUNT  = 8'h0C;

    // control word fields
    localparam int unsigned CTRL_CLEAR_BIT = 31;
    localparam int unsigned CTRL_START_BIT = 0;

    typedef struct packed {
        logic [DATA_W-1:0]  ctrl;
        logic [COUNT_W-1:0] reload;
        logic [COUNT_W-1:0] count;
        logic               run;
    } tmr_state_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        tick_o  = run_i && !clr_i && (phase_q == LAST);
        phase_d = phase_q;
        if (clr_i || !run_i) begin
            phase_d = '0;
        end else if (phase_q == LAST) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R11: a cleared prescaler cannot tick on the following clock
            a_r11_clear_delays_tick: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> !tick_o);
            // R7: ticks are never back to back when the divider exceeds one
            a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               ctrl_we_i,
    input  logic               reload_we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               tick_i,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic [COUNT_W-1:0] reload_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               run_o
);
    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (ctrl_we_i) begin
                st_d.ctrl = wdata_i;
                if (wdata_i[CTRL_START_BIT]) st_d.run = 1'b1;
            end
            if (reload_we_i) begin
                st_d.reload = wdata_i[COUNT_W-1:0];
                st_d.count  = wdata_i[COUNT_W-1:0];
            end else if (tick_i) begin
                if (st_q.count == '0) st_d.count = st_q.reload;
                else                  st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign run_o    = st_q.run;

    // R2: soft reset leaves nothing behind
    a_r2_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ctrl_o == '0 && reload_o == '0 && count_o == '0 && !run_o));
    // R4: only a soft reset stops a running timer
    a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !clear_i) |=> run_o);
    // R5: reload write lands in both reload and count
    a_r5_reload_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
        reload_we_i |=> (count_o == $past(wdata_i[COUNT_W-1:0])
                         && reload_o == $past(wdata_i[COUNT_W-1:0])));
    // R7: a tick on a nonzero count steps down by exactly one
    a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !reload_we_i && !clear_i && count_o != '0)
            |=> count_o == $past(count_o) - 1'b1);
    // R8: zero reload keeps a zero count at zero
    a_r8_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && reload_o == '0 && !reload_we_i && !clear_i) |=> count_o == '0);
    // R3: a stopped timer keeps its count until written
    a_r3_stopped_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !ctrl_we_i && !reload_we_i && !clear_i) |=> $stable(count_o));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 250_000_000,
    parameter int unsigned TICK_HZ = 1_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  logic                we_i,
    input  logic [WIN_BITS-1:0] offs_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic hit_ctrl, hit_reload, hit_count;
    logic clear_w, ctrl_we, reload_we, start_w;
    logic tick;
    logic [DATA_W-1:0]  ctrl_v;
    logic [COUNT_W-1:0] reload_v, count_v;
    logic run_v;

    always_comb begin
        hit_ctrl   = sel_i && (offs_i == OFS_CTRL);
        hit_reload = sel_i && (offs_i == OFS_RELOAD);
        hit_count  = sel_i && (offs_i == OFS_COUNT);
        clear_w    = we_i && hit_ctrl && wdata_i[CTRL_CLEAR_BIT];
        ctrl_we    = we_i && hit_ctrl && !wdata_i[CTRL_CLEAR_BIT];
        start_w    = ctrl_we && wdata_i[CTRL_START_BIT];
        reload_we  = we_i && hit_reload;
    end

    tmr_prescaler #(.DIV(DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_v),
        .clr_i  (clear_w || start_w),
        .tick_o (tick)
    );

    tmr_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_w),
        .ctrl_we_i   (ctrl_we),
        .reload_we_i (reload_we),
        .wdata_i     (wdata_i),
        .tick_i      (tick),
        .ctrl_o      (ctrl_v),
        .reload_o    (reload_v),
        .count_o     (count_v),
        .run_o       (run_v)
    );

    always_comb begin
        rdata_o = '0;
        if (hit_ctrl)   rdata_o = ctrl_v;
        if (hit_reload) rdata_o = {{(DATA_W-COUNT_W){1'b0}}, reload_v};
        if (hit_count)  rdata_o = {{(DATA_W-COUNT_W){1'b0}}, count_v};
    end

    // R6: a write to the count offset leaves the count untouched unless a tick is due
    a_r6_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_count && !tick) |=> $stable(count_v));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h4000_0000,
    parameter int unsigned        N_UNITS   = 3,
    parameter int unsigned        CLK_HZ    = 250_000_000,
    parameter int unsigned        TICK_HZ   = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(N_UNITS * (2 ** WIN_BITS));

    logic [ADDR_W-1:0] rel;
    logic              bank_hit;
    logic [N_UNITS-1:0] unit_sel;
    logic [DATA_W-1:0] unit_rdata [N_UNITS];

    always_comb begin
        rel      = bus_addr - BASE_ADDR;
        bank_hit = (bus_addr >= BASE_ADDR) && (rel < SPAN);
    end

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            assign unit_sel[u] = bank_hit
                && (rel[ADDR_W-1:WIN_BITS] == (ADDR_W-WIN_BITS)'(u));

            tmr_unit #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel_i   (unit_sel[u]),
                .we_i    (bus_wr),
                .offs_i  (rel[WIN_BITS-1:0]),
                .wdata_i (bus_wdata),
                .rdata_o (unit_rdata[u])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int u = 0; u < N_UNITS; u++) bus_rdata = bus_rdata | unit_rdata[u];
    end

    // R9: at most one window decodes any address
    a_r9_single_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_sel));
    // R10: addresses outside every window read zero
    a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_hit |-> bus_rdata == '0);

endmodule

// File: tb/tb_tmr_bank.sv
`timescale 1ns/100ps
module tb_tmr_bank;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int DIV = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // behavioural reference
    logic [31:0] m_ctrl [3];
    int          m_rel  [3];
    int          m_cnt  [3];
    bit          m_run  [3];
    int          m_pre  [3];
    logic [31:0] w_rel;
    int          w_idx;
    int          w_off;
    bit          w_hit, w_tk, w_start;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_ctrl[i] = 0; m_rel[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_pre[i] = 0;
            end
        end else begin
            w_rel = bus_addr - BASE;
            w_idx = int'(w_rel / 256);
            w_off = int'(w_rel % 256);
            for (int i = 0; i < 3; i++) begin
                w_hit = bus_wr && (bus_addr >= BASE) && (w_rel < 768) && (w_idx == i);
                w_tk  = m_run[i] && (m_pre[i] == DIV - 1);
                if (w_hit && w_off == 0 && bus_wdata[31]) begin
                    m_ctrl[i] = 0; m_rel[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_pre[i] = 0;
                end else begin
                    w_start = w_hit && w_off == 0 && bus_wdata[0];
                    if (w_hit && w_off == 0) m_ctrl[i] = bus_wdata;
                    if (w_start) begin
                        m_run[i] = 1; m_pre[i] = 0; w_tk = 0;
                    end else if (m_run[i]) begin
                        m_pre[i] = (m_pre[i] == DIV - 1) ? 0 : m_pre[i] + 1;
                    end
                    if (w_hit && w_off == 8) begin
                        m_rel[i] = int'(bus_wdata[15:0]);
                        m_cnt[i] = int'(bus_wdata[15:0]);
                    end else if (w_tk) begin
                        m_cnt[i] = (m_cnt[i] == 0) ? m_rel[i] : m_cnt[i] - 1;
                    end
                end
            end
        end
    end

    function automatic logic [31:0] model_read(logic [31:0] a);
        logic [31:0] r = a - BASE;
        int idx, off;
        if (a < BASE || r >= 768) return 32'h0;
        idx = int'(r / 256);
        off = int'(r % 256);
        case (off)
            0:  return m_ctrl[idx];
            8:  return 32'(m_rel[idx]);
            12: return 32'(m_cnt[idx]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference (R6 readback path)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R6 per-cycle readback", bus_rdata, model_read(bus_addr));
    end

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk); #0.5;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #0.5;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [31:0] a, logic [31:0] exp);
        @(negedge clk); #0.5;
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic [31:0] nxt(logic [31:0] c, logic [31:0] rl);
        return (c == 0) ? rl : c - 1;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(100000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    logic [31:0] c0;

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1 ctrl", BASE + 32'h00, 32'h0);
        rd_chk("R1 reload", BASE + 32'h08, 32'h0);
        rd_chk("R1 count", BASE + 32'h0C, 32'h0);
        rd_chk("R1 inst2 count", BASE + 32'h20C, 32'h0);

        // R5: reload keeps low half and loads count
        wr(BASE + 32'h08, 32'hABCD_0005);
        rd_chk("R5 reload low half", BASE + 32'h08, 32'h0000_0005);
        rd_chk("R5 count loaded", BASE + 32'h0C, 32'h0000_0005);
        // R6: count write ignored
        wr(BASE + 32'h0C, 32'h0000_1234);
        rd_chk("R6 count write ignored", BASE + 32'h0C, 32'h0000_0005);

        // R3 / R7 / R11: start and exact first tick
        wr(BASE + 32'h00, 32'h0000_0101);
        bus_addr = BASE + 32'h0C;
        repeat (DIV - 1) @(negedge clk);
        chk("R11 no tick before divider", bus_rdata, 32'h5);
        @(negedge clk);
        chk("R7 first decrement", bus_rdata, 32'h4);
        repeat (4 * DIV) @(negedge clk);
        chk("R7 reaches zero", bus_rdata, 32'h0);
        repeat (DIV) @(negedge clk);
        chk("R7 wraps to reload", bus_rdata, 32'h5);
        rd_chk("R3 ctrl stored", BASE + 32'h00, 32'h0000_0101);

        // R4: bit0 clear does not stop
        wr(BASE + 32'h00, 32'h0000_0002);
        bus_addr = BASE + 32'h0C;
        #0.5 c0 = bus_rdata;
        repeat (DIV) @(negedge clk);
        chk("R4 still counting", bus_rdata, nxt(c0, 32'h5));
        repeat (DIV) @(negedge clk);
        chk("R4 still counting 2", bus_rdata, nxt(nxt(c0, 32'h5), 32'h5));
        rd_chk("R4 ctrl stored", BASE + 32'h00, 32'h0000_0002);

        // R11: restart mid-period realigns phase
        repeat (37) @(negedge clk);
        wr(BASE + 32'h00, 32'h0000_0001);
        bus_addr = BASE + 32'h0C;
        #0.5 c0 = bus_rdata;
        repeat (DIV - 1) @(negedge clk);
        chk("R11 restart holds count", bus_rdata, c0);
        @(negedge clk);
        chk("R11 restart tick phase", bus_rdata, nxt(c0, 32'h5));

        // R2: soft reset
        wr(BASE + 32'h00, 32'h8000_0001);
        rd_chk("R2 ctrl cleared", BASE + 32'h00, 32'h0);
        rd_chk("R2 reload cleared", BASE + 32'h08, 32'h0);
        rd_chk("R2 count cleared", BASE + 32'h0C, 32'h0);
        repeat (2 * DIV) @(negedge clk);
        chk("R2 stays stopped", bus_rdata, 32'h0);

        // R8: zero reload while running
        wr(BASE + 32'h00, 32'h0000_0001);
        bus_addr = BASE + 32'h0C;
        repeat (3 * DIV) @(negedge clk);
        chk("R8 zero hold", bus_rdata, 32'h0);
        // R5 on a running timer
        wr(BASE + 32'h08, 32'h0000_0003);
        bus_addr = BASE + 32'h0C;
        #0.5 chk("R5 running reload", bus_rdata, 32'h3);

        // R9: instances independent
        wr(BASE + 32'h108, 32'h0000_0007);
        wr(BASE + 32'h208, 32'h0000_0009);
        wr(BASE + 32'h200, 32'h0000_0001);
        bus_addr = BASE + 32'h20C;
        repeat (DIV) @(negedge clk);
        chk("R9 inst2 ticks", bus_rdata, 32'h8);
        rd_chk("R9 inst1 stopped", BASE + 32'h10C, 32'h7);
        rd_chk("R9 inst0 reload kept", BASE + 32'h08, 32'h3);
        rd_chk("R9 inst1 ctrl", BASE + 32'h100, 32'h0);

        // R10: unmapped
        wr(BASE + 32'h104, 32'hFFFF_FFFF);
        rd_chk("R10 hole write ctrl", BASE + 32'h100, 32'h0);
        rd_chk("R10 hole write reload", BASE + 32'h108, 32'h7);
        rd_chk("R10 hole read", BASE + 32'h104, 32'h0);
        rd_chk("R10 offset 0x10", BASE + 32'h010, 32'h0);
        rd_chk("R10 offset 0xFC", BASE + 32'h2FC, 32'h0);
        rd_chk("R10 misaligned", BASE + 32'h001, 32'h0);
        wr(BASE + 32'h308, 32'h0000_0055);
        rd_chk("R10 past bank", BASE + 32'h308, 32'h0);
        rd_chk("R10 below base", BASE - 32'h4, 32'h0);
        rd_chk("R10 inst2 reload kept", BASE + 32'h208, 32'h9);

        // R1: hardware reset while running
        @(negedge clk); #0.5 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #0.5 rst_n = 1'b1;
        rd_chk("R1 inst0 ctrl after reset", BASE + 32'h00, 32'h0);
        rd_chk("R1 inst2 reload after reset", BASE + 32'h208, 32'h0);
        bus_addr = BASE + 32'h20C;
        repeat (2 * DIV) @(negedge clk);
        chk("R1 inst2 stopped after reset", bus_rdata, 32'h0);

        finish_run();
    end

endmodule